// File: doc/BRIEF.md
# Memory Controller Client Port Sequencer

This block sits between a simple request interface and the native user port of an external-memory controller. A requester hands it one transaction at a time: either a write that carries an address, one data beat and a byte mask, or a read that carries an address. The block turns each request into a command on the controller's command channel and, for writes, a beat on the controller's write-data channel. These are two separate ready/strobe handshakes, and the controller may refuse either one in any cycle. A refused command is held unchanged and offered again until the controller takes it. A write beat may go out before its command or in the same cycle, but never after it.

Read data flows back as a stream of beats, each with an end-of-burst flag. The block registers every beat once and presents it on the response side in the order the reads were issued. It keeps a count of reads that have been accepted but not yet completed, and stops taking new reads when that count reaches a parameter limit. The size and self-refresh inputs of the controller are held low. The error-correction enable is held high when the ECC parameter is set.

Top module: `mcClientSeq`

## Requirements
- R1: While the command strobe is high and the controller's command-ready is low, the strobe, address, command code and priority stay high and unchanged in the next cycle.
- R2: While the write-data strobe is high and write-data-ready is low, the strobe, data and mask stay high and unchanged in the next cycle.
- R3: A write command is offered only when its write-data beat has already been accepted, or is accepted in the same cycle. The number of accepted write commands never exceeds the number of accepted write beats.
- R4: Every write transaction is one beat, so the write-data end flag is high in every cycle in which the write-data strobe is high.
- R5: The response outputs (valid, data and last) follow the controller's read valid, data and end flag one cycle later. Last is high only together with valid. Responses arrive in the order the reads were issued.
- R6: Read accesses are counted from request acceptance until the controller delivers their end-flagged beat. When MAX_RD reads are counted, the request-ready output is low for a read request. It goes high again once a read completes.
- R7: The size input and the self-refresh request input of the controller are 0 at all times. The correction enable equals the ECC_EN parameter (1 by default).
- R8: The command code is 3'b000 for a write and 3'b001 for a read. The address is forwarded unchanged from the request.
- R9: The priority output carries the request's high-priority bit while its command is offered, and is 0 when no command is offered.
- R10: After synchronous active-high reset, both strobes and the response valid are low. The request-ready output is high.
- R11: Only one request is in flight inside the block. The request-ready output stays low while a command or a write beat is still waiting for the controller.
- R12: Mask bit i travels with byte i of the write beat. A mask bit of 1 leaves that byte of memory unchanged; a mask bit of 0 writes the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usrValid | input | 1 | Request offered |
| usrReady | output | 1 | Request accepted this cycle when valid is high |
| usrWrite | input | 1 | 1 = write request, 0 = read request |
| usrAddr | input | ADDR_W | Request address |
| usrHiPri | input | 1 | Raise the priority of this request |
| usrData | input | DATA_W | Write beat |
| usrMask | input | DATA_W/8 | Byte mask, 1 = keep the byte |
| rspValid | output | 1 | Read response beat valid |
| rspData | output | DATA_W | Read response beat |
| rspLast | output | 1 | Last beat of a read |
| mcCmdEn | output | 1 | Command strobe to the controller |
| mcCmd | output | 3 | Command code |
| mcAddr | output | ADDR_W | Command address |
| mcHiPri | output | 1 | Command priority |
| mcSz | output | 1 | Reserved size input, held 0 |
| mcRdy | input | 1 | Controller accepts a command |
| mcWdfWren | output | 1 | Write-data strobe |
| mcWdfData | output | DATA_W | Write-data beat |
| mcWdfMask | output | DATA_W/8 | Write-data byte mask |
| mcWdfEnd | output | 1 | Last write beat of a transaction |
| mcWdfRdy | input | 1 | Controller accepts a write beat |
| mcRdDataValid | input | 1 | Read beat valid from controller |
| mcRdData | input | DATA_W | Read beat from controller |
| mcRdDataEnd | input | 1 | Last read beat, meaningful only with valid |
| mcSrReq | output | 1 | Reserved self-refresh request, held 0 |
| mcCorrectEn | output | 1 | Single-bit correction enable |

## Verification
A stale pending flag shows up as a command or beat that is dropped or repeated. The memory-backed responder then returns a wrong read value within a few cycles of the next read of that address. An off-by-one in the beat lead counter lets a write command reach the controller ahead of its data, and the bench flags this in the cycle the command is offered. A read counter that drifts either blocks reads early or lets more than MAX_RD reads through. Either error is visible on the request-ready output as soon as the responder withholds read data. A broken response register shifts or loses a beat, and the next ordered comparison against the expected value catches it.

// File: rtl/seqPkg.sv
package seqPkg;

  // Command codes on the controller's command field
  typedef enum logic [2:0] {
    CMD_WRITE = 3'b000,
    CMD_READ  = 3'b001
  } mcCmd_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // capture the user request into the holding registers
    logic cmdOffer;  // a command is on the controller's command channel
  } seqStrobe_t;

endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
#(
  parameter int MAX_RD = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       usrValid,
  input  logic       usrWrite,
  output logic       usrReady,
  input  logic       mcRdy,
  input  logic       mcWdfRdy,
  input  logic       mcRdDataValid,
  input  logic       mcRdDataEnd,
  output logic       mcCmdEn,
  output logic       mcWdfWren,
  output logic       mcWdfEnd,
  output seqStrobe_t strobe
);

  localparam int RD_CNT_W = $clog2(MAX_RD + 1);
  localparam logic [RD_CNT_W-1:0] RD_LIMIT = RD_CNT_W'(MAX_RD);

  logic                cmdPend;
  logic                cmdIsRd;
  logic                wdPend;
  logic [1:0]          beatsAhead;
  logic [RD_CNT_W-1:0] rdCount;

  logic usrAccept, wdAccept, cmdOffer, cmdAccept, wrCmdAccept;
  logic rdInc, rdDec;

  // User side: one request at a time, reads gated by the outstanding limit
  assign usrReady  = !cmdPend && !wdPend && (usrWrite || (rdCount < RD_LIMIT));
  assign usrAccept = usrValid && usrReady;

  // Write-data channel runs on its own handshake
  assign mcWdfWren = wdPend;
  assign mcWdfEnd  = wdPend;   // single-beat transactions
  assign wdAccept  = wdPend && mcWdfRdy;

  // A write command waits until its beat has gone or is going now
  assign cmdOffer    = cmdPend && (cmdIsRd || (beatsAhead != 2'd0) || wdAccept);
  assign cmdAccept   = cmdOffer && mcRdy;
  assign wrCmdAccept = cmdAccept && !cmdIsRd;
  assign mcCmdEn     = cmdOffer;

  assign rdInc = usrAccept && !usrWrite;
  assign rdDec = mcRdDataValid && mcRdDataEnd && (rdCount != '0);

  assign strobe.loadReq  = usrAccept;
  assign strobe.cmdOffer = cmdOffer;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdPend    <= 1'b0;
      cmdIsRd    <= 1'b0;
      wdPend     <= 1'b0;
      beatsAhead <= 2'd0;
      rdCount    <= '0;
    end else begin
      if (usrAccept) begin
        cmdPend <= 1'b1;
        cmdIsRd <= !usrWrite;
      end else if (cmdAccept) begin
        cmdPend <= 1'b0;
      end

      if (usrAccept && usrWrite) wdPend <= 1'b1;
      else if (wdAccept)         wdPend <= 1'b0;

      beatsAhead <= beatsAhead + 2'(wdAccept) - 2'(wrCmdAccept);

      case ({rdInc, rdDec})
        2'b10:   rdCount <= rdCount + 1'b1;
        2'b01:   rdCount <= rdCount - 1'b1;
        default: rdCount <= rdCount;
      endcase
    end
  end

  // R3
  beat_lead_chk: assert property (@(posedge clk) disable iff (rst)
    beatsAhead <= 2'd1);

  // R6
  rd_limit_chk: assert property (@(posedge clk) disable iff (rst)
    rdCount <= RD_LIMIT);

  // R5
  rd_return_chk: assert property (@(posedge clk) disable iff (rst)
    mcRdDataValid |-> (rdCount != '0));

  // R11
  one_flight_chk: assert property (@(posedge clk) disable iff (rst)
    usrAccept |=> !usrReady);

endmodule

// File: rtl/seqData.sv
module seqData
  import seqPkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  parameter int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic              usrWrite,
  input  logic [ADDR_W-1:0] usrAddr,
  input  logic              usrHiPri,
  input  logic [DATA_W-1:0] usrData,
  input  logic [MASK_W-1:0] usrMask,
  input  logic              mcRdDataValid,
  input  logic [DATA_W-1:0] mcRdData,
  input  logic              mcRdDataEnd,
  output logic [ADDR_W-1:0] mcAddr,
  output logic [2:0]        mcCmd,
  output logic              mcHiPri,
  output logic [DATA_W-1:0] mcWdfData,
  output logic [MASK_W-1:0] mcWdfMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspLast
);

  logic [ADDR_W-1:0] addrQ;
  mcCmd_e            cmdQ;
  logic              hiPriQ;
  logic [DATA_W-1:0] dataQ;
  logic [MASK_W-1:0] maskQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      cmdQ   <= CMD_WRITE;
      hiPriQ <= 1'b0;
      dataQ  <= '0;
      maskQ  <= '0;
    end else if (strobe.loadReq) begin
      addrQ  <= usrAddr;
      cmdQ   <= usrWrite ? CMD_WRITE : CMD_READ;
      hiPriQ <= usrHiPri;
      dataQ  <= usrData;
      maskQ  <= usrMask;
    end
  end

  assign mcAddr    = addrQ;
  assign mcCmd     = cmdQ;
  assign mcHiPri   = strobe.cmdOffer && hiPriQ;
  assign mcWdfData = dataQ;
  assign mcWdfMask = maskQ;

  // Return path: one register stage, end flag qualified by valid
  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspLast  <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= mcRdDataValid;
      rspLast  <= mcRdDataValid && mcRdDataEnd;
      if (mcRdDataValid) rspData <= mcRdData;
    end
  end

  // R1
  hold_regs_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadReq |=> ($stable(mcAddr) && $stable(mcCmd) && $stable(mcWdfData) && $stable(mcWdfMask)));

  // R8
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.cmdOffer |-> (mcCmd == 3'b000 || mcCmd == 3'b001));

endmodule

// File: rtl/mcClientSeq.sv
module mcClientSeq
  import seqPkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  parameter int MAX_RD = 4,
  parameter bit ECC_EN = 1'b1,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              usrValid,
  output logic              usrReady,
  input  logic              usrWrite,
  input  logic [ADDR_W-1:0] usrAddr,
  input  logic              usrHiPri,
  input  logic [DATA_W-1:0] usrData,
  input  logic [MASK_W-1:0] usrMask,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspLast,
  output logic              mcCmdEn,
  output logic [2:0]        mcCmd,
  output logic [ADDR_W-1:0] mcAddr,
  output logic              mcHiPri,
  output logic              mcSz,
  input  logic              mcRdy,
  output logic              mcWdfWren,
  output logic [DATA_W-1:0] mcWdfData,
  output logic [MASK_W-1:0] mcWdfMask,
  output logic              mcWdfEnd,
  input  logic              mcWdfRdy,
  input  logic              mcRdDataValid,
  input  logic [DATA_W-1:0] mcRdData,
  input  logic              mcRdDataEnd,
  output logic              mcSrReq,
  output logic              mcCorrectEn
);

  seqStrobe_t strobe;

  seqCtrl #(.MAX_RD(MAX_RD)) uCtrl (
    .clk(clk), .rst(rst),
    .usrValid(usrValid), .usrWrite(usrWrite), .usrReady(usrReady),
    .mcRdy(mcRdy), .mcWdfRdy(mcWdfRdy),
    .mcRdDataValid(mcRdDataValid), .mcRdDataEnd(mcRdDataEnd),
    .mcCmdEn(mcCmdEn), .mcWdfWren(mcWdfWren), .mcWdfEnd(mcWdfEnd),
    .strobe(strobe)
  );

  seqData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) uData (
    .clk(clk), .rst(rst), .strobe(strobe),
    .usrWrite(usrWrite), .usrAddr(usrAddr), .usrHiPri(usrHiPri),
    .usrData(usrData), .usrMask(usrMask),
    .mcRdDataValid(mcRdDataValid), .mcRdData(mcRdData), .mcRdDataEnd(mcRdDataEnd),
    .mcAddr(mcAddr), .mcCmd(mcCmd), .mcHiPri(mcHiPri),
    .mcWdfData(mcWdfData), .mcWdfMask(mcWdfMask),
    .rspValid(rspValid), .rspData(rspData), .rspLast(rspLast)
  );

  // Reserved controller inputs
  assign mcSz    = 1'b0;
  assign mcSrReq = 1'b0;

  generate
    if (ECC_EN) begin : gEcc
      assign mcCorrectEn = 1'b1;
    end else begin : gNoEcc
      assign mcCorrectEn = 1'b0;
    end
  endgenerate

  // R1
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mcCmdEn && !mcRdy) |=> (mcCmdEn && $stable(mcAddr) && $stable(mcCmd) && $stable(mcHiPri)));

  // R2
  wdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mcWdfWren && !mcWdfRdy) |=> (mcWdfWren && $stable(mcWdfData) && $stable(mcWdfMask)));

  // R11
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mcCmdEn || mcWdfWren) |-> !usrReady);

endmodule

// File: tb/sim_mcClientSeq.sv
module sim_mcClientSeq;

  localparam int ADDR_W   = 28;
  localparam int DATA_W   = 32;
  localparam int MASK_W   = 4;
  localparam int MAX_RD   = 4;
  localparam int RD_BEATS = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst = 1'b1;
  logic              usrValid = 1'b0, usrWrite = 1'b0, usrHiPri = 1'b0;
  logic [ADDR_W-1:0] usrAddr = '0;
  logic [DATA_W-1:0] usrData = '0;
  logic [MASK_W-1:0] usrMask = '0;
  logic              usrReady, rspValid, rspLast;
  logic [DATA_W-1:0] rspData;
  logic              mcCmdEn, mcHiPri, mcSz, mcWdfWren, mcWdfEnd, mcSrReq, mcCorrectEn;
  logic [2:0]        mcCmd;
  logic [ADDR_W-1:0] mcAddr;
  logic [DATA_W-1:0] mcWdfData;
  logic [MASK_W-1:0] mcWdfMask;
  logic              mcRdy = 1'b0, mcWdfRdy = 1'b0, mcRdDataValid = 1'b0, mcRdDataEnd = 1'b0;
  logic [DATA_W-1:0] mcRdData = '0;

  mcClientSeq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_RD(MAX_RD), .ECC_EN(1'b1)) u0 (.*);

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [31:0] devMem [16];
  logic [31:0] refMem [16];
  logic [31:0] rdQ [$];
  logic [35:0] beatQ [$];
  logic [31:0] expQ [$];
  int rdyMode = 0, wdfMode = 0;
  bit retEnable = 1'b1;
  int beatIdx = 0, rspIdx = 0, beatCnt = 0, wrCmdCnt = 0, benchOut = 0;
  logic [31:0] lastRsp0 = '0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic pick(int m);
    if (m == 1) return 1'b0;
    if (m == 2) return 1'b1;
    return logic'($urandom % 2);
  endfunction

  function automatic logic [31:0] applyMask(logic [31:0] old, logic [31:0] d, logic [3:0] m);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (!m[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  // Memory-backed controller responder
  always @(negedge clk) begin
    if (rst) begin
      mcRdy = 1'b0; mcWdfRdy = 1'b0; mcRdDataValid = 1'b0; mcRdDataEnd = 1'b0;
    end else begin
      mcRdy    = pick(rdyMode);
      mcWdfRdy = pick(wdfMode);
      if (retEnable && rdQ.size() > 0 && ($urandom % 4 != 0)) begin
        mcRdDataValid = 1'b1;
        mcRdData      = (beatIdx == 0) ? rdQ[0] : ~rdQ[0];
        mcRdDataEnd   = (beatIdx == RD_BEATS - 1);
        if (beatIdx == RD_BEATS - 1) begin
          beatIdx = 0;
          void'(rdQ.pop_front());
        end else beatIdx++;
      end else begin
        mcRdDataValid = 1'b0;
        mcRdDataEnd   = logic'($urandom % 2);
        mcRdData      = $urandom;
      end
    end
  end

  // Continuous monitor, sampled mid-cycle ahead of the next rising edge
  logic pCmdHeld = 0, pWdHeld = 0, pRdV = 0, pRdE = 0, pHiPri = 0;
  logic [ADDR_W-1:0] pAddr = '0;
  logic [2:0] pCmd = '0;
  logic [DATA_W-1:0] pData = '0, pRdD = '0;
  logic [MASK_W-1:0] pMask = '0;

  always @(negedge clk) begin
    #2;
    if (!rst) begin
      // R1 refused command held
      if (pCmdHeld)
        chk(mcCmdEn && mcAddr == pAddr && mcCmd == pCmd && mcHiPri == pHiPri, "R1", "command hold",
            {mcCmdEn, mcCmd, mcAddr}, {1'b1, pCmd, pAddr});
      // R2 refused beat held
      if (pWdHeld)
        chk(mcWdfWren && mcWdfData == pData && mcWdfMask == pMask, "R2", "beat hold",
            {mcWdfWren, mcWdfData}, {1'b1, pData});
      // R4 end flag on every beat
      if (mcWdfWren) chk(mcWdfEnd, "R4", "write end flag", mcWdfEnd, 1);
      // R7 reserved inputs
      chk(!mcSz && !mcSrReq && mcCorrectEn, "R7", "fixed inputs", {mcSz, mcSrReq, mcCorrectEn}, 3'b001);
      // R9 priority idle
      if (!mcCmdEn) chk(!mcHiPri, "R9", "priority without command", mcHiPri, 0);
      // beat accepted this cycle
      if (mcWdfWren && mcWdfRdy) begin
        beatQ.push_back({mcWdfMask, mcWdfData});
        beatCnt++;
      end
      if (mcCmdEn) begin
        if (mcCmd == 3'b000) chk(beatCnt > wrCmdCnt, "R3", "write command ahead of data", wrCmdCnt, beatCnt);
        else chk(mcCmd == 3'b001, "R8", "command code", mcCmd, 1);
        if (mcRdy) begin
          if (mcCmd == 3'b000) begin
            logic [35:0] bt;
            wrCmdCnt++;
            if (beatQ.size() > 0) begin
              bt = beatQ.pop_front();
              devMem[mcAddr[3:0]] = applyMask(devMem[mcAddr[3:0]], bt[31:0], bt[35:32]);
            end
          end else begin
            rdQ.push_back(devMem[mcAddr[3:0]]);
          end
        end
      end
      // R6 outstanding limit
      if (usrValid && !usrWrite && benchOut >= MAX_RD)
        chk(!usrReady, "R6", "read taken over the limit", usrReady, 0);
      // user-side acceptance updates the reference model
      if (usrValid && usrReady) begin
        if (usrWrite) refMem[usrAddr[3:0]] = applyMask(refMem[usrAddr[3:0]], usrData, usrMask);
        else begin
          expQ.push_back(refMem[usrAddr[3:0]]);
          benchOut++;
        end
      end
      if (mcRdDataValid && mcRdDataEnd) benchOut--;
      // R5 response follows the controller beat by one cycle, in order
      chk(rspValid == pRdV, "R5", "response valid timing", rspValid, pRdV);
      if (rspValid) begin
        logic [31:0] ev;
        ev = (expQ.size() > 0) ? expQ[0] : 32'hDEAD_BEEF;
        if (rspIdx != 0) ev = ~ev;
        chk(rspData == ev, "R5", "response data", rspData, ev);
        chk(rspLast == (rspIdx == RD_BEATS - 1), "R5", "response last", rspLast, rspIdx == RD_BEATS - 1);
        if (rspIdx == 0) lastRsp0 = rspData;
        if (rspIdx == RD_BEATS - 1) begin
          rspIdx = 0;
          if (expQ.size() > 0) void'(expQ.pop_front());
        end else rspIdx++;
      end else begin
        chk(!rspLast, "R5", "last without valid", rspLast, 0);
      end
      pCmdHeld = mcCmdEn && !mcRdy;
      pWdHeld  = mcWdfWren && !mcWdfRdy;
      pAddr = mcAddr; pCmd = mcCmd; pHiPri = mcHiPri;
      pData = mcWdfData; pMask = mcWdfMask;
      pRdV = mcRdDataValid; pRdE = mcRdDataEnd; pRdD = mcRdData;
    end else begin
      pCmdHeld = 0; pWdHeld = 0; pRdV = 0;
    end
  end

  task automatic setModes(int r, int w);
    rdyMode = r; wdfMode = w;
    mcRdy = pick(r); mcWdfRdy = pick(w);
  endtask

  task automatic userReq(bit wr, logic [ADDR_W-1:0] a, logic [31:0] d, logic [3:0] m, bit hp);
    bit got = 0;
    @(negedge clk);
    usrValid = 1'b1; usrWrite = wr; usrAddr = a; usrData = d; usrMask = m; usrHiPri = hp;
    while (!got) begin
      #1;
      if (usrReady) got = 1;
      else @(negedge clk);
    end
    @(negedge clk);
    usrValid = 1'b0; usrWrite = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((expQ.size() != 0 || rdQ.size() != 0 || mcCmdEn || mcWdfWren) && n < 2000) begin
      @(negedge clk); #1; n++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #3;
    chk(usrReady, "R10", "ready after reset", usrReady, 1);
    chk(!mcCmdEn && !mcWdfWren, "R10", "strobes after reset", {mcCmdEn, mcWdfWren}, 0);
    chk(!rspValid, "R10", "response after reset", rspValid, 0);
    chk(!mcSz && !mcSrReq && mcCorrectEn, "R7", "fixed inputs after reset", {mcSz, mcSrReq, mcCorrectEn}, 3'b001);
  endtask

  task automatic testBeatFirst();
    @(negedge clk); #1 setModes(2, 1);
    userReq(1'b1, 28'd5, 32'hA5A5_0001, 4'b0000, 1'b0);
    repeat (3) begin
      #3;
      chk(mcWdfWren, "R2", "beat offered", mcWdfWren, 1);
      chk(!mcCmdEn, "R3", "write command waits for beat", mcCmdEn, 0);
      @(negedge clk);
    end
    #1 setModes(2, 2);
    #2;
    chk(mcCmdEn, "R3", "write command with beat", mcCmdEn, 1);
    chk(mcCmd == 3'b000, "R8", "write code", mcCmd, 0);
    chk(mcAddr == 28'd5, "R8", "write address", mcAddr, 5);
    chk(mcWdfEnd, "R4", "end flag on beat", mcWdfEnd, 1);
    drain();
  endtask

  task automatic testHold();
    @(negedge clk); #1 setModes(1, 2);
    userReq(1'b0, 28'd9, 32'h0, 4'h0, 1'b1);
    repeat (3) begin
      #3;
      chk(mcCmdEn && mcCmd == 3'b001, "R8", "read offered", {mcCmdEn, mcCmd}, 4'b1001);
      chk(mcAddr == 28'd9, "R1", "held address", mcAddr, 9);
      chk(mcHiPri, "R9", "priority forwarded", mcHiPri, 1);
      chk(!usrReady, "R11", "busy while pending", usrReady, 0);
      @(negedge clk);
    end
    #1 setModes(2, 2);
    drain();
    #3 chk(!mcHiPri, "R9", "priority cleared", mcHiPri, 0);
  endtask

  task automatic testMask();
    @(negedge clk); #1 setModes(0, 0);
    userReq(1'b1, 28'd3, 32'h1122_3344, 4'b0000, 1'b0);
    userReq(1'b1, 28'd3, 32'hAABB_CCDD, 4'b0101, 1'b0);
    userReq(1'b0, 28'd3, 32'h0, 4'h0, 1'b0);
    drain();
    chk(lastRsp0 == 32'hAA22_CC44, "R12", "masked merge", lastRsp0, 32'hAA22_CC44);
  endtask

  task automatic testLimit();
    @(negedge clk); #1 setModes(2, 2);
    retEnable = 1'b0;
    for (int i = 0; i < MAX_RD; i++) userReq(1'b0, ADDR_W'(i), 32'h0, 4'h0, 1'b0);
    usrValid = 1'b1; usrWrite = 1'b0; usrAddr = 28'd7;
    repeat (4) begin
      #3 chk(!usrReady, "R6", "read blocked at limit", usrReady, 0);
      @(negedge clk);
    end
    usrValid = 1'b0;
    retEnable = 1'b1;
    drain();
    #3 chk(usrReady, "R6", "read allowed after return", usrReady, 1);
  endtask

  task automatic testRandom();
    @(negedge clk); #1 setModes(0, 0);
    for (int i = 0; i < 60; i++)
      userReq(logic'($urandom % 2), ADDR_W'($urandom % 16), $urandom, 4'($urandom % 16), logic'($urandom % 2));
    drain();
    chk(expQ.size() == 0, "R5", "all reads returned", expQ.size(), 0);
    chk(wrCmdCnt == beatCnt, "R3", "write commands match beats", wrCmdCnt, beatCnt);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin devMem[i] = '0; refMem[i] = '0; end
    testReset();
    testBeatFirst();
    testHold();
    testMask();
    testLimit();
    testRandom();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule